// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port Controller

The controller owns a small bank of general-purpose pins and is programmed through a simple register bus. The bus carries an address, a write strobe, write data and combinational read data, and it has no handshake. Software can drive any pin as an output and can read back every pin's level. Any input pin can be set up as an interrupt source. For each pin it chooses level or edge detection, the active polarity, an optional debounce filter and a mask. Raw status shows every qualified event. Masked status shows only the unmasked ones and feeds a single interrupt line.

Pin inputs first pass through a two-flop synchroniser. A pin with debounce enabled then passes through a filter that accepts a new level only after it has been held for a fixed number of clocks. Edge events latch and stay set until software writes ones to the acknowledge register. Level events are not latched and follow the pin. One control bit adds a register stage to level detection so that it is timed to the bus clock.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every control register reads 0, pin_out, pin_oe and irq are 0, and both status registers read 0.
- R2: Writing offset 0x00 sets the output data; bits 7:0 appear on pin_out one clock after the write and read back, and bits 31:8 read as 0.
- R3: Offset 0x04 holds direction (bit = 1 output, pin_oe high; 0 input); a pin set as output never sets a raw status bit.
- R4: Offset 0x50 reads the pin levels in bits 7:0 after the two-flop synchroniser: a change is visible at the second clock edge after it, not at the first.
- R5: A pin whose bit in the enable register (0x30) is 0 never sets its raw status bit (0x44), whatever its type and polarity.
- R6: A type bit (0x38) of 1 selects edge detection; with polarity bit (0x3C) 1 a rising edge latches the raw bit, and it stays set after the pin returns low.
- R7: With edge type and polarity 0, a falling edge latches the raw bit and a rising edge does not.
- R8: With type 0 (level), the raw bit equals the pin at its active level (high for polarity 1, low for polarity 0) and clears as soon as the pin leaves that level.
- R9: A mask bit (0x34) of 1 clears that pin in masked status (0x40) and in irq, and leaves raw status unchanged; mask 0 passes it through.
- R10: Writing ones to offset 0x4C clears the matching latched edge bits; zero bits leave them set; the offset reads 0.
- R11: irq is high exactly when at least one masked status bit is set.
- R12: With debounce (0x48) set on a pin, a level held for 3 clocks is ignored and a level held for 4 clocks is accepted.
- R13: With bit 0 of offset 0x60 set, level detection takes one clock longer (raw set at the third edge after the pin change instead of the second); the bit reads back in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPIN | Pin levels from the pads |
| pin_out | output | NPIN | Output data to the pads |
| pin_oe | output | NPIN | Output enable per pin (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
A stuck or stale edge latch shows directly in raw status and irq on the cycle after an acknowledge write, so the acknowledge checks read status immediately. A synchroniser or debounce counter that is off by one changes the cycle on which a level first appears at offset 0x50 or in raw status, so those tests sample on exact clock counts. The 3-cycle and 4-cycle pulses bound the filter length from both sides. A wrong qualification (enable, direction, mask) shows as a status bit or irq set while the pin is active, and that is visible within a few clocks of the stimulus.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_DOUT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_IMSK  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_ITYP  = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_IPOL  = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_MSTAT = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_RSTAT = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_DEB   = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_ACK   = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_EXT   = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_LSYNC = 8'h60;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign d_out = st_q.s2;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
    parameter int unsigned W    = 8,
    parameter int unsigned HOLD = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] en,
    output logic [W-1:0] filt
);
    localparam int unsigned CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

    for (genvar g = 0; g < W; g++) begin : g_pin
        typedef struct packed {
            logic [CNT_W-1:0] cnt;
            logic             val;
        } deb_t;

        deb_t st_d, st_q;

        always_comb begin
            st_d     = st_q;
            st_d.cnt = '0;
            if (raw[g] != st_q.val) begin
                if (st_q.cnt == LAST) st_d.val = raw[g];
                else                  st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign filt[g] = en[g] ? st_q.val : raw[g];
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_v,
    input  logic [W-1:0] qual,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] ack_clr,
    input  logic         lsync,
    output logic [W-1:0] raw
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] edge_lat;
        logic [W-1:0] lvl;
    } det_t;

    det_t st_d, st_q;
    logic [W-1:0] act_lvl, edge_hit, lvl_now, edge_ok, lvl_ok;

    always_comb begin
        act_lvl  = ~(pin_v ^ pol);
        edge_hit = (pin_v ^ st_q.prev) & act_lvl;
        edge_ok  = qual & edge_sel;
        lvl_ok   = qual & ~edge_sel;
        lvl_now  = act_lvl & lvl_ok;

        st_d.prev     = pin_v;
        st_d.edge_lat = ((st_q.edge_lat & ~ack_clr) | edge_hit) & edge_ok;
        st_d.lvl      = lvl_now;

        raw = (st_q.edge_lat & edge_ok)
            | ((lsync ? st_q.lvl : lvl_now) & lvl_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned NPIN     = 8,
    parameter int unsigned DEB_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq
);
    typedef struct packed {
        logic [NPIN-1:0] dout;
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] ien;
        logic [NPIN-1:0] imsk;
        logic [NPIN-1:0] ityp;
        logic [NPIN-1:0] ipol;
        logic [NPIN-1:0] deb;
        logic            lsync;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [NPIN-1:0] pin_sync, pin_val, ack_clr, raw_stat, mstat;
    logic [NPIN-1:0] imsk_w, ien_w;
    logic            wdata_unused;

    assign wdata_unused = ^bus_wdata[DATA_W-1:NPIN];

    // Register writes
    always_comb begin
        cfg_d   = cfg_q;
        ack_clr = '0;
        if (bus_we) begin
            case (bus_addr)
                OFS_DOUT:  cfg_d.dout  = bus_wdata[NPIN-1:0];
                OFS_DIR:   cfg_d.dir   = bus_wdata[NPIN-1:0];
                OFS_IEN:   cfg_d.ien   = bus_wdata[NPIN-1:0];
                OFS_IMSK:  cfg_d.imsk  = bus_wdata[NPIN-1:0];
                OFS_ITYP:  cfg_d.ityp  = bus_wdata[NPIN-1:0];
                OFS_IPOL:  cfg_d.ipol  = bus_wdata[NPIN-1:0];
                OFS_DEB:   cfg_d.deb   = bus_wdata[NPIN-1:0];
                OFS_LSYNC: cfg_d.lsync = bus_wdata[0];
                OFS_ACK:   ack_clr     = bus_wdata[NPIN-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    gpio_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .d_out (pin_sync)
    );

    gpio_debounce #(.W(NPIN), .HOLD(DEB_HOLD)) u_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pin_sync),
        .en    (cfg_q.deb),
        .filt  (pin_val)
    );

    gpio_irq_detect #(.W(NPIN)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_v    (pin_val),
        .qual     (cfg_q.ien & ~cfg_q.dir),
        .edge_sel (cfg_q.ityp),
        .pol      (cfg_q.ipol),
        .ack_clr  (ack_clr),
        .lsync    (cfg_q.lsync),
        .raw      (raw_stat)
    );

    assign mstat   = raw_stat & ~cfg_q.imsk;
    assign irq     = |mstat;
    assign pin_out = cfg_q.dout;
    assign pin_oe  = cfg_q.dir;
    assign imsk_w  = cfg_q.imsk;
    assign ien_w   = cfg_q.ien;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DOUT:  bus_rdata[NPIN-1:0] = cfg_q.dout;
            OFS_DIR:   bus_rdata[NPIN-1:0] = cfg_q.dir;
            OFS_IEN:   bus_rdata[NPIN-1:0] = cfg_q.ien;
            OFS_IMSK:  bus_rdata[NPIN-1:0] = cfg_q.imsk;
            OFS_ITYP:  bus_rdata[NPIN-1:0] = cfg_q.ityp;
            OFS_IPOL:  bus_rdata[NPIN-1:0] = cfg_q.ipol;
            OFS_DEB:   bus_rdata[NPIN-1:0] = cfg_q.deb;
            OFS_MSTAT: bus_rdata[NPIN-1:0] = mstat;
            OFS_RSTAT: bus_rdata[NPIN-1:0] = raw_stat;
            OFS_EXT:   bus_rdata[NPIN-1:0] = pin_val;
            OFS_LSYNC: bus_rdata[0]        = cfg_q.lsync;
            default: ;
        endcase
    end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned NPIN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   pin_oe,
    input logic              irq,
    input logic [NPIN-1:0]   raw_stat,
    input logic [NPIN-1:0]   imsk_w,
    input logic [NPIN-1:0]   ien_w
);
    AST_DOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DOUT) |=> pin_out == $past(bus_wdata[NPIN-1:0])); // R2
    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DIR) |=> pin_oe == $past(bus_wdata[NPIN-1:0])); // R3
    AST_OUTPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat & pin_oe) == '0); // R3
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat & ~ien_w) == '0); // R5
    AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_ACK) |-> bus_rdata == '0); // R10
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_stat & ~imsk_w) != '0); // R11
    AST_SOURCE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_stat & ~imsk_w) != '0) |-> irq); // R11
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .raw_stat  (raw_stat),
    .imsk_w    (imsk_w),
    .ien_w     (ien_w)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
    import gpio_port_pkg::*;

    localparam int unsigned NPIN = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NPIN-1:0]   pin_in = '0;
    logic [NPIN-1:0]   pin_out, pin_oe;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_irq_port #(.NPIN(NPIN)) u_dut (
        .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
        .pin_in, .pin_out, .pin_oe, .irq
    );

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] expv;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{OFS_DOUT,  32'hFFFF_FFA5, 32'h0000_00A5},
        '{OFS_DIR,   32'h0000_FF3C, 32'h0000_003C},
        '{OFS_IMSK,  32'h1234_5681, 32'h0000_0081},
        '{OFS_ITYP,  32'h0000_00F0, 32'h0000_00F0},
        '{OFS_IPOL,  32'h0000_000F, 32'h0000_000F},
        '{OFS_DEB,   32'h0000_0155, 32'h0000_0055},
        '{OFS_LSYNC, 32'hFFFF_FFFE, 32'h0000_0000},
        '{OFS_LSYNC, 32'h0000_0003, 32'h0000_0001},
        '{OFS_ACK,   32'h0000_00FF, 32'h0000_0000},
        '{OFS_IEN,   32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pin_in = '0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
    endtask

    task automatic pulse(input int b, input int n);
        @(negedge clk);
        pin_in[b] = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        pin_in[b] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        foreach (VEC[i]) begin
            rd(VEC[i].addr, v);
            chk("R1", "reset register", v, 32'h0);
        end
        rd(OFS_RSTAT, v); chk("R1", "reset raw status", v, 32'h0);
        rd(OFS_MSTAT, v); chk("R1", "reset masked status", v, 32'h0);
        chk("R1", "reset pin_out", 32'(pin_out), 32'h0);
        chk("R1", "reset pin_oe", 32'(pin_oe), 32'h0);
        chk("R1", "reset irq", 32'(irq), 32'h0);

        // Table walk: write and read back (R2, R3, R10, R13)
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i].addr, VEC[i].wdata);
            rd(VEC[i].addr, v);
            chk("R2/R3/R10/R13", $sformatf("readback %h", VEC[i].addr), v, VEC[i].expv);
        end
        chk("R2", "pin_out drive", 32'(pin_out), 32'h0000_00A5);
        chk("R3", "pin_oe drive", 32'(pin_oe), 32'h0000_003C);

        do_reset();

        // R4 external port latency through synchroniser
        @(negedge clk);
        pin_in = 8'h5A;
        wait_clk(1);
        rd(OFS_EXT, v); chk("R4", "ext after one edge", v, 32'h0);
        wait_clk(1);
        rd(OFS_EXT, v); chk("R4", "ext after two edges", v, 32'h5A);
        @(negedge clk); pin_in = '0;
        wait_clk(4);

        // R5 disabled pins never raise status
        wr(OFS_ITYP, 32'hFF); wr(OFS_IPOL, 32'hFF);
        @(negedge clk); pin_in = 8'hFF;
        wait_clk(5);
        rd(OFS_RSTAT, v); chk("R5", "raw with enable off", v, 32'h0);
        chk("R5", "irq with enable off", 32'(irq), 32'h0);
        @(negedge clk); pin_in = '0;
        wait_clk(5);

        // R6 rising edge latch on pin 0
        wr(OFS_ITYP, 32'h01); wr(OFS_IPOL, 32'h01); wr(OFS_IEN, 32'h01);
        @(negedge clk); pin_in[0] = 1'b1;
        wait_clk(5);
        rd(OFS_RSTAT, v); chk("R6", "raw after rise", v, 32'h01);
        chk("R11", "irq after rise", 32'(irq), 32'h1);
        @(negedge clk); pin_in[0] = 1'b0;
        wait_clk(5);
        rd(OFS_RSTAT, v); chk("R6", "raw latched after fall", v, 32'h01);

        // R10 acknowledge
        wr(OFS_ACK, 32'h00);
        rd(OFS_RSTAT, v); chk("R10", "zero ack keeps latch", v, 32'h01);
        wr(OFS_ACK, 32'h01);
        rd(OFS_RSTAT, v); chk("R10", "ack clears latch", v, 32'h0);
        chk("R10", "irq after ack", 32'(irq), 32'h0);

        // R7 falling edge on pin 1
        wr(OFS_ITYP, 32'h02); wr(OFS_IPOL, 32'h00); wr(OFS_IEN, 32'h02);
        @(negedge clk); pin_in[1] = 1'b1;
        wait_clk(5);
        rd(OFS_RSTAT, v); chk("R7", "rise ignored", v, 32'h0);
        @(negedge clk); pin_in[1] = 1'b0;
        wait_clk(5);
        rd(OFS_RSTAT, v); chk("R7", "fall latched", v, 32'h02);
        wr(OFS_ACK, 32'h02);

        // R8 level on pin 2
        wr(OFS_ITYP, 32'h00); wr(OFS_IPOL, 32'h04); wr(OFS_IEN, 32'h04);
        @(negedge clk); pin_in[2] = 1'b1;
        wait_clk(5);
        rd(OFS_RSTAT, v); chk("R8", "high level active", v, 32'h04);
        @(negedge clk); pin_in[2] = 1'b0;
        wait_clk(5);
        rd(OFS_RSTAT, v); chk("R8", "level not latched", v, 32'h0);
        wr(OFS_IPOL, 32'h00);
        wait_clk(3);
        rd(OFS_RSTAT, v); chk("R8", "low level active", v, 32'h04);

        // R9 mask
        wr(OFS_IMSK, 32'h04);
        rd(OFS_RSTAT, v); chk("R9", "raw unaffected by mask", v, 32'h04);
        rd(OFS_MSTAT, v); chk("R9", "masked status blocked", v, 32'h0);
        chk("R9", "irq blocked", 32'(irq), 32'h0);
        wr(OFS_IMSK, 32'h00);
        rd(OFS_MSTAT, v); chk("R9", "masked status passes", v, 32'h04);
        chk("R11", "irq from level", 32'(irq), 32'h1);

        // R3 output pin never interrupts
        wr(OFS_DIR, 32'h04);
        wait_clk(2);
        rd(OFS_RSTAT, v); chk("R3", "output pin quiet", v, 32'h0);
        chk("R3", "irq with output pin", 32'(irq), 32'h0);
        wr(OFS_DIR, 32'h00);

        // R13 level sync adds one clock
        wr(OFS_IPOL, 32'h04);
        wait_clk(3);
        @(negedge clk); pin_in[2] = 1'b1;
        wait_clk(2);
        rd(OFS_RSTAT, v); chk("R13", "unsynced level at second edge", v, 32'h04);
        @(negedge clk); pin_in[2] = 1'b0;
        wait_clk(5);
        wr(OFS_LSYNC, 32'h1);
        @(negedge clk); pin_in[2] = 1'b1;
        wait_clk(2);
        rd(OFS_RSTAT, v); chk("R13", "synced level not yet at second edge", v, 32'h0);
        wait_clk(1);
        rd(OFS_RSTAT, v); chk("R13", "synced level at third edge", v, 32'h04);
        @(negedge clk); pin_in[2] = 1'b0;
        wr(OFS_LSYNC, 32'h0);
        wait_clk(5);

        // R12 debounce on pin 3 (rising edge latch as observer)
        wr(OFS_DEB, 32'h08); wr(OFS_ITYP, 32'h08);
        wr(OFS_IPOL, 32'h08); wr(OFS_IEN, 32'h08);
        wait_clk(6);
        pulse(3, 3);
        wait_clk(10);
        rd(OFS_RSTAT, v); chk("R12", "3-cycle pulse ignored", v, 32'h0);
        rd(OFS_EXT, v);   chk("R12", "ext after short pulse", v, 32'h0);
        pulse(3, 4);
        wait_clk(10);
        rd(OFS_RSTAT, v); chk("R12", "4-cycle pulse accepted", v, 32'h08);
        @(negedge clk); pin_in[3] = 1'b1;
        wait_clk(6);
        rd(OFS_EXT, v);   chk("R12", "ext filtered high", v, 32'h08);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule